// File: doc/BRIEF.md
# Prioritized 64-Source Interrupt Controller

This block collects 64 level-sensitive request lines and presents a single interrupt to a processor. Each clock it registers the request lines as pending bits. Software can also assert any source through a force register. A source takes part in arbitration only when three things hold: it is requesting (pending or forced), it is enabled, and it is not masked. A source is enabled when its per-source priority byte is nonzero.

Among the participating sources, the one with the largest priority byte wins. A tie goes to the higher-numbered source. The winner's interrupt level and an 8-bit vector number are driven out through registers. When nothing is active, a fixed spurious vector is driven with level zero.

Software reaches all state through a plain register bus with byte addresses and 32-bit data. The bus has these accesses:
- pending, mask and force words;
- one priority byte per source;
- two single-byte commands that set or clear one mask bit, or the whole mask;
- a read-only acknowledge word that returns the current vector.

There is no streaming data path, so the bus and the interrupt outputs are plain signals without handshakes. A write completes in the cycle where `bus_sel` and `bus_wr` are both high. Read data is combinational from `bus_addr` while `bus_sel` is high and `bus_wr` is low. Otherwise read data is zero.

Top module: `prio_intc`

## Requirements
- R1: While `rst` is high and after it falls, the state is: mask all ones; pending, force and all priority bytes zero; `irq_vector` = 24; `irq_level` = 0.
- R2: The pending register takes the value of `irq_in` at every clock edge. Byte 0x00 reads pending bits 63:32 and byte 0x04 reads bits 31:0. Writes to 0x00 and 0x04 change nothing.
- R3: Byte 0x08 reads and writes mask bits 63:32, and byte 0x0C reads and writes mask bits 31:0. A mask bit of 1 blocks its source.
- R4: Byte 0x10 reads and writes force bits 63:32, and byte 0x14 reads and writes bits 31:0. A forced source requests exactly as a pending one does.
- R5: A write to byte 0x40+n stores `bus_wdata[5:0]` as the priority byte of source n. A read of that byte returns the stored value zero-extended. The source is enabled exactly when its stored byte is nonzero.
- R6: A source is active when (pending OR forced) AND enabled AND NOT masked.
- R7: The winner is the active source with the largest priority byte. Equal bytes go to the higher source number.
- R8: With winner n, `irq_vector` = 64+n and `irq_level` = priority byte bits [5:3]. With no active source, `irq_vector` = 24 and `irq_level` = 0.
- R9: Outputs reflect a register write one clock after the write edge. They reflect an `irq_in` change two clock edges after it is applied.
- R10: A write to byte 0x1C sets the mask bit numbered by `bus_wdata[5:0]`. When `bus_wdata[6]` is 1, it sets all 64 mask bits instead.
- R11: A write to byte 0x1D clears the mask bit numbered by `bus_wdata[5:0]`. When `bus_wdata[6]` is 1, it clears all 64 mask bits instead.
- R12: A read of byte 0xE0 returns the current `irq_vector`. Bytes 0xE1 to 0xE7 and every unmapped byte read as zero. Writes to unmapped bytes leave mask, force and priority state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | 64 | Level-sensitive request lines, bit n is source n |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data; byte registers use bits 7:0 |
| bus_rdata | output | 32 | Read data, combinational |
| irq_level | output | 3 | Level of the winning source, 0 when none |
| irq_vector | output | 8 | Vector of the winning source, 24 when none |

## Verification
A corrupted mask, force or priority bit shows up at the outputs as a wrong winner. The vector then names the wrong source, or the spurious value appears while a source should win. This shows one clock after the write that caused it, and it can also be read back through the bus in the same cycle.

A fault in the arbitration order surfaces only when two or more active sources compete. For that reason the bench removes winners one at a time from a field with repeated priority values, so every tie is decided at the ports.

A pending-path fault shows two edges after a line changes, both on `irq_vector` and in the pending words.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NSRC   = 64;
  localparam int HALF   = NSRC / 2;
  localparam int IDX_W  = $clog2(NSRC);
  localparam int PRIO_W = 6;
  localparam int LVL_W  = 3;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_PEND_HI  = 8'h00;
  localparam logic [ADDR_W-1:0] A_PEND_LO  = 8'h04;
  localparam logic [ADDR_W-1:0] A_MASK_HI  = 8'h08;
  localparam logic [ADDR_W-1:0] A_MASK_LO  = 8'h0C;
  localparam logic [ADDR_W-1:0] A_FRC_HI   = 8'h10;
  localparam logic [ADDR_W-1:0] A_FRC_LO   = 8'h14;
  localparam logic [ADDR_W-1:0] A_MSET     = 8'h1C;
  localparam logic [ADDR_W-1:0] A_MCLR     = 8'h1D;
  localparam logic [ADDR_W-1:0] A_ACK      = 8'hE0;
  localparam logic [1:0]        PRIO_PAGE  = 2'b01;

  typedef logic [NSRC-1:0][PRIO_W-1:0] prio_arr_t;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   irq_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [7:0]        cur_vector,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NSRC-1:0]   active,
  output prio_arr_t         prio
);
  logic [NSRC-1:0] pend_q, mask_q, frc_q, en;
  prio_arr_t       prio_q;
  logic            wr_en;
  logic [IDX_W-1:0] cmd_idx;
  logic            cmd_all;

  assign wr_en   = bus_sel & bus_wr;
  assign cmd_idx = bus_wdata[IDX_W-1:0];
  assign cmd_all = bus_wdata[IDX_W];

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= irq_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
    end else if (wr_en) begin
      case (bus_addr)
        A_MASK_HI: mask_q[NSRC-1:HALF] <= bus_wdata;
        A_MASK_LO: mask_q[HALF-1:0]    <= bus_wdata;
        A_MSET: begin
          if (cmd_all) mask_q <= '1;
          else         mask_q[cmd_idx] <= 1'b1;
        end
        A_MCLR: begin
          if (cmd_all) mask_q <= '0;
          else         mask_q[cmd_idx] <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frc_q <= '0;
    end else if (wr_en) begin
      if (bus_addr == A_FRC_HI) frc_q[NSRC-1:HALF] <= bus_wdata;
      if (bus_addr == A_FRC_LO) frc_q[HALF-1:0]    <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prio_q <= '0;
    end else if (wr_en && bus_addr[ADDR_W-1:IDX_W] == PRIO_PAGE) begin
      prio_q[bus_addr[IDX_W-1:0]] <= bus_wdata[PRIO_W-1:0];
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_en
    assign en[g] = |prio_q[g];
  end

  assign active = (pend_q | frc_q) & en & ~mask_q;
  assign prio   = prio_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (bus_addr[ADDR_W-1:IDX_W] == PRIO_PAGE) begin
        bus_rdata = DATA_W'(prio_q[bus_addr[IDX_W-1:0]]);
      end else begin
        case (bus_addr)
          A_PEND_HI: bus_rdata = pend_q[NSRC-1:HALF];
          A_PEND_LO: bus_rdata = pend_q[HALF-1:0];
          A_MASK_HI: bus_rdata = mask_q[NSRC-1:HALF];
          A_MASK_LO: bus_rdata = mask_q[HALF-1:0];
          A_FRC_HI:  bus_rdata = frc_q[NSRC-1:HALF];
          A_FRC_LO:  bus_rdata = frc_q[HALF-1:0];
          A_ACK:     bus_rdata = DATA_W'(cur_vector);
          default:   bus_rdata = '0;
        endcase
      end
    end
  end

  // R2: pending holds the line values sampled at the previous edge
  a_r2_pend_follows: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pend_q == $past(irq_in));
  // R10: set-all command
  a_r10_set_all: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bus_addr == A_MSET && cmd_all) |=> mask_q == '1);
  // R11: clear-all command
  a_r11_clr_all: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bus_addr == A_MCLR && cmd_all) |=> mask_q == '0);
  // R12: unmapped write leaves state alone
  a_r12_unmapped_quiet: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bus_addr == 8'h20) |=> ($stable(mask_q) && $stable(frc_q) && $stable(prio_q)));
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
(
  input  logic [NSRC-1:0]  active,
  input  prio_arr_t        prio,
  output logic             found,
  output logic [IDX_W-1:0] win_idx,
  output logic [PRIO_W-1:0] win_prio
);
  always_comb begin
    found    = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (active[i] && prio[i] >= win_prio) begin
        found    = 1'b1;
        win_idx  = IDX_W'(i);
        win_prio = prio[i];
      end
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter logic [7:0] SPUR_VEC = 8'd24,
  parameter logic [7:0] VEC_BASE = 8'd64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [63:0] irq_in,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [2:0]  irq_level,
  output logic [7:0]  irq_vector
);
  logic [NSRC-1:0]   active;
  prio_arr_t         prio;
  logic              found;
  logic [IDX_W-1:0]  win_idx;
  logic [PRIO_W-1:0] win_prio;

  intc_regs u_regs (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .cur_vector(irq_vector), .bus_rdata(bus_rdata),
    .active(active), .prio(prio)
  );

  intc_arbiter u_arb (
    .active(active), .prio(prio),
    .found(found), .win_idx(win_idx), .win_prio(win_prio)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_vector <= SPUR_VEC;
      irq_level  <= '0;
    end else if (found) begin
      irq_vector <= VEC_BASE + 8'(win_idx);
      irq_level  <= win_prio[PRIO_W-1:PRIO_W-LVL_W];
    end else begin
      irq_vector <= SPUR_VEC;
      irq_level  <= '0;
    end
  end

  // R1: reset leaves the spurious vector and level zero
  a_r1_reset_out: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq_vector == SPUR_VEC && irq_level == 3'd0));
  // R8: spurious vector always comes with level zero
  a_r8_spur_level: assert property (@(posedge clk) disable iff (rst)
    irq_vector == SPUR_VEC |-> irq_level == 3'd0);
  // R8: vector is either spurious or in the source window
  a_r8_vec_range: assert property (@(posedge clk) disable iff (rst)
    irq_vector == SPUR_VEC || (irq_vector >= VEC_BASE && irq_vector < VEC_BASE + 8'(NSRC)));
  // R7: the selected source is one that is active
  a_r7_winner_active: assert property (@(posedge clk) disable iff (rst)
    found |-> active[win_idx]);
endmodule

// File: tb/prio_intc_tb.sv
module prio_intc_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] irq_in = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq_level;
  logic [7:0]  irq_vector;

  int checks = 0, errors = 0;
  logic [63:0] m_pend = '0, m_frc = '0, m_mask = '1;
  int m_prio [64];

  prio_intc u_dut (.*);

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  function automatic int exp_win();
    int best = -1, bl = 0;
    for (int i = 0; i < 64; i++)
      if ((m_pend[i] | m_frc[i]) && m_prio[i] != 0 && !m_mask[i] && m_prio[i] >= bl) begin
        bl = m_prio[i]; best = i;
      end
    return best;
  endfunction

  task automatic chk_out(input string tag);
    int w = exp_win();
    chk({tag, " vector"}, 32'(irq_vector), (w < 0) ? 32'd24 : 32'(64 + w));
    chk({tag, " level"}, 32'(irq_level), (w < 0) ? 32'd0 : 32'(m_prio[w] >> 3));
  endtask

  task automatic wr_frc(input logic [63:0] v);
    wr(8'h10, v[63:32]); wr(8'h14, v[31:0]); m_frc = v;
  endtask

  initial begin
    #1_900_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) m_prio[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk_out("R1 reset");
    rdchk("R1 mask hi", 8'h08, 32'hFFFF_FFFF);
    rdchk("R1 mask lo", 8'h0C, 32'hFFFF_FFFF);
    rdchk("R1 pend", 8'h00, 32'h0);
    rdchk("R1 force", 8'h14, 32'h0);
    rdchk("R1 prio", 8'h45, 32'h0);
    rdchk("R1 ack", 8'hE0, 32'd24);
    // R11 clear all
    wr(8'h1D, 32'h40); m_mask = '0;
    rdchk("R11 clr all hi", 8'h08, 32'h0);
    rdchk("R11 clr all lo", 8'h0C, 32'h0);
    // R3 mask halves
    wr(8'h08, 32'hA5A5_0F0F); wr(8'h0C, 32'h1234_5678);
    rdchk("R3 mask hi", 8'h08, 32'hA5A5_0F0F);
    rdchk("R3 mask lo", 8'h0C, 32'h1234_5678);
    wr(8'h08, 32'h0); wr(8'h0C, 32'h0);
    // single-source sweep: R4 R5 R6 R8 R10 R11
    for (int n = 0; n < 64; n++) begin
      int pv = (n % 63) + 1;
      wr(8'(8'h40 + n), 32'(pv)); m_prio[n] = pv;
      rdchk("R5 prio readback", 8'(8'h40 + n), 32'(pv));
      wr_frc(64'd1 << n);
      settle(); chk_out("R4 R8 single forced");
      wr(8'h1C, 32'(n)); m_mask[n] = 1'b1;
      settle(); chk_out("R10 R6 masked single");
      wr(8'h1D, 32'(n)); m_mask[n] = 1'b0;
      settle(); chk_out("R11 unmasked single");
      wr(8'(8'h40 + n), 32'h0); m_prio[n] = 0;
      settle(); chk_out("R5 disabled by zero");
    end
    // tie field: R7 with repeated priority values, mask winners one by one
    for (int n = 0; n < 64; n++) begin
      m_prio[n] = ((n % 16) * 4) & 63;
      wr(8'(8'h40 + n), 32'hC0 | 32'(m_prio[n]));
    end
    rdchk("R5 upper bits dropped", 8'h47, 32'd28);
    wr_frc('1);
    for (int k = 0; k < 64; k++) begin
      int w;
      settle(); chk_out("R7 tie sweep");
      w = exp_win();
      if (w < 0) break;
      wr(8'h1C, 32'(w)); m_mask[w] = 1'b1;
    end
    wr(8'h1D, 32'h40); m_mask = '0;
    settle(); chk_out("R11 clear all restores");
    wr(8'h1C, 32'h40); m_mask = '1;
    settle(); chk_out("R10 set all");
    rdchk("R10 set all read", 8'h0C, 32'hFFFF_FFFF);
    wr(8'h1D, 32'd17); m_mask[17] = 1'b0;
    settle(); chk_out("R11 single clear");
    // pending path R2 R9
    wr_frc('0);
    wr(8'h1D, 32'h40); m_mask = '0;
    settle(); chk_out("R6 nothing requested");
    @(negedge clk);
    irq_in = (64'd1 << 5) | (64'd1 << 40);
    @(negedge clk);
    chk("R9 line not yet visible", 32'(irq_vector), 32'd24);
    @(negedge clk);
    m_pend = irq_in;
    chk_out("R9 R2 line after two edges");
    rdchk("R2 pend hi", 8'h00, 32'h100);
    rdchk("R2 pend lo", 8'h04, 32'h20);
    wr(8'h00, 32'hFFFF_FFFF); wr(8'h04, 32'hFFFF_FFFF);
    rdchk("R2 write ignored hi", 8'h00, 32'h100);
    rdchk("R2 write ignored lo", 8'h04, 32'h20);
    irq_in = '0; m_pend = '0;
    settle(); chk_out("R2 line dropped");
    // R9 write timing
    wr(8'h14, 32'h8);
    chk("R9 write not yet visible", 32'(irq_vector), 32'd24);
    @(negedge clk);
    m_frc = 64'h8;
    chk_out("R9 write after one edge");
    // R12 acknowledge and unmapped
    rdchk("R12 ack", 8'hE0, 32'd67);
    rdchk("R12 E3 zero", 8'hE3, 32'h0);
    rdchk("R12 unmapped zero", 8'h20, 32'h0);
    wr(8'h20, 32'hFFFF_FFFF); wr(8'h18, 32'hFFFF_FFFF); wr(8'hE0, 32'hFF);
    rdchk("R12 mask untouched", 8'h0C, 32'h0);
    rdchk("R12 force untouched", 8'h14, 32'h8);
    settle(); chk_out("R12 outputs untouched");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule